// File: doc/BRIEF.md
# Serial Controller Queue and Interrupt Unit

This block sits between a register bus decoder and the shift engine of a serial controller. It holds a transmit queue and a receive queue, each `DEPTH` words of `DW` bits. A single data register offset is shared by both queues: a bus write there appends a word to the transmit queue, and a bus read there removes the oldest word from the receive queue. The shift engine takes transmit words through a show-ahead head and a pop strobe. It delivers received words through a push strobe.

A control register holds one fill threshold for each direction and one flush trigger for each direction. From the queue levels and those thresholds, the block derives sticky pending events: receive overrun, receive level reached, and transmit drained. It also derives two DMA request lines, one for each direction. Each pending event and each DMA request is gated by an enable register. The pending events are acknowledged by writing ones to the interrupt status offset.

Register word offsets: 0 control, 1 status, 2 interrupt enable, 3 interrupt status/clear, 4 data. Any other offset reads as zero and is ignored on write. Read data appears on `reg_rdata` one cycle after `reg_rd`.

Top module: `txrxq_top`

## Requirements
- R1: After a synchronous reset, both queues are empty, `tx_avail`, `irq`, `tx_dma_req` and `rx_dma_req` are low, and the status, control and enable registers read as zero.
- R2: A write to offset 4 appends `reg_wdata` to the transmit queue. The engine sees the words on `tx_word` in write order, and each `tx_pop` removes one. A write while `DEPTH` words are held is dropped.
- R3: Words pushed with `rx_push` are returned in arrival order by reads of offset 4. A read of offset 4 with the receive queue empty returns zero.
- R4: At offset 0, bits 11:8 hold the transmit threshold and bits 3:0 hold the receive threshold, and both read back. Writing 1 to bit 12 empties the transmit queue, and writing 1 to bit 4 empties the receive queue. Bits 12 and 4 read as zero.
- R5: At offset 1, bit 0 is set while the receive queue is not empty. Bit 7 (busy) is set while `eng_busy` is high or the transmit queue holds words.
- R6: An `rx_push` while the receive queue holds `DEPTH` words drops the incoming word and sets the overrun pending bit (offset 3, bit 0).
- R7: At offset 3, bit 3 (receive complete) becomes pending once the receive occupancy is non-zero and at or above the receive threshold. Bit 9 shows that same comparison live. Bit 4 (transmit complete) becomes pending while the transmit queue is empty and `eng_busy` is low.
- R8: Writing 1 to bit 4, 3 or 0 at offset 3 clears that pending bit, and writing 0 leaves it unchanged. A bit whose condition still holds becomes pending again.
- R9: `irq` is high when any pending bit among 4, 3 and 0 has its matching enable set at offset 2 (same bit positions), and low otherwise.
- R10: `tx_dma_req` is high when enable bit 2 is set and the transmit free space is non-zero and at or above the transmit threshold. `rx_dma_req` is high when enable bit 1 is set and the receive occupancy is non-zero and at or above the receive threshold.
- R11: Register read data is presented on `reg_rdata` in the cycle after `reg_rd`, and a data read removes exactly one receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| tx_pop | input | 1 | Engine takes the transmit head word |
| tx_word | output | DW | Transmit head word (show-ahead) |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | DW | Received word |
| eng_busy | input | 1 | Shift engine is mid-transfer |
| irq | output | 1 | Registered interrupt line |
| tx_dma_req | output | 1 | Registered transmit DMA request |
| rx_dma_req | output | 1 | Registered receive DMA request |

## Verification
The bound checker enforces, on every cycle, several relations that do not depend on stimulus. A transmit flush leaves the queue empty on the next cycle. The interrupt line and both DMA request lines stay low when their enables or pending bits are off. A push into a full receive queue always raises overrun, and the transmit level never moves without a push, pop or flush. Ordering, dropping of words past capacity, threshold crossings, and the interplay between acknowledging an event and its condition re-arming can only be shown by the directed scenarios, which compare read-back values and output levels against expectations.

// File: rtl/txrxq_pkg.sv
package txrxq_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_IEN   = 3'd2,
    A_ISTAT = 3'd3,
    A_DATA  = 3'd4
  } reg_off_e;

  localparam int IRQ_W = 5;

  // control register field positions
  localparam int B_RXTHR   = 0;
  localparam int B_RXFLUSH = 4;
  localparam int B_TXTHR   = 8;
  localparam int B_TXFLUSH = 12;

  // status register
  localparam int B_RXNE = 0;
  localparam int B_BUSY = 7;

  // enable / pending bit positions
  localparam int B_OVR    = 0;
  localparam int B_RXDMA  = 1;
  localparam int B_TXDMA  = 2;
  localparam int B_RXDONE = 3;
  localparam int B_TXDONE = 4;
  localparam int B_RXLVL  = 9;

  // bits that are sticky pending events and can drive irq
  localparam logic [IRQ_W-1:0] PEND_MASK = 5'b11001;

endpackage

// File: rtl/txrxq_fifo.sv
module txrxq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_push = push && (cnt != CW'(DEPTH)) && !flush;
  assign do_pop  = pop && (cnt != '0) && !flush;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign count = cnt;
  assign empty = (cnt == '0);

endmodule

// File: rtl/txrxq_irq.sv
module txrxq_irq
  import txrxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TH_W  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [TH_W-1:0]  tx_thr,
  input  logic [TH_W-1:0]  rx_thr,
  input  logic             eng_busy,
  input  logic             ovr_evt,
  input  logic [IRQ_W-1:0] clr,
  input  logic [IRQ_W-1:0] ien,
  output logic [IRQ_W-1:0] pend,
  output logic             rx_lvl,
  output logic             irq,
  output logic             tx_dma,
  output logic             rx_dma
);

  int unsigned     tx_free;
  logic            rx_hit, tx_hit, tx_idle;
  logic [IRQ_W-1:0] set_v;

  assign tx_free = DEPTH - int'(tx_cnt);
  assign rx_hit  = (rx_cnt != '0) && (int'(rx_cnt) >= int'(rx_thr));
  assign tx_hit  = (tx_free != 0) && (tx_free >= int'(tx_thr));
  assign tx_idle = (tx_cnt == '0) && !eng_busy;
  assign rx_lvl  = rx_hit;

  always_comb begin
    set_v           = '0;
    set_v[B_OVR]    = ovr_evt;
    set_v[B_RXDONE] = rx_hit;
    set_v[B_TXDONE] = tx_idle;
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_pend
    if (PEND_MASK[i]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) pend[i] <= 1'b0;
        else     pend[i] <= (pend[i] & ~clr[i]) | set_v[i];
      end
    end else begin : g_none
      assign pend[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      tx_dma <= 1'b0;
      rx_dma <= 1'b0;
    end else begin
      irq    <= |(pend & ien & PEND_MASK);
      tx_dma <= ien[B_TXDMA] & tx_hit;
      rx_dma <= ien[B_RXDMA] & rx_hit;
    end
  end

endmodule

// File: rtl/txrxq_top.sv
module txrxq_top
  import txrxq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int TH_W  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_word,
  output logic          tx_avail,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_word,
  input  logic          eng_busy,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  logic [TH_W-1:0]  tx_thr_q, rx_thr_q;
  logic [IRQ_W-1:0] ien_q, pend_w, clr_w;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [DW-1:0]    rx_head, rd_mux;
  logic             tx_empty, rx_empty, rx_lvl;
  logic             wr_ctrl, tx_flush, rx_flush, ovr_evt;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign tx_flush = wr_ctrl && reg_wdata[B_TXFLUSH];
  assign rx_flush = wr_ctrl && reg_wdata[B_RXFLUSH];
  assign clr_w    = (reg_wr && (reg_addr == A_ISTAT)) ? reg_wdata[IRQ_W-1:0] : '0;
  assign ovr_evt  = rx_push && (rx_cnt == CW'(DEPTH));

  txrxq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (tx_flush),
    .push  (reg_wr && (reg_addr == A_DATA)),
    .pdata (reg_wdata),
    .pop   (tx_pop),
    .head  (tx_word),
    .count (tx_cnt),
    .empty (tx_empty)
  );

  txrxq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (rx_flush),
    .push  (rx_push),
    .pdata (rx_word),
    .pop   (reg_rd && (reg_addr == A_DATA)),
    .head  (rx_head),
    .count (rx_cnt),
    .empty (rx_empty)
  );

  txrxq_irq #(.DEPTH(DEPTH), .TH_W(TH_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .tx_thr   (tx_thr_q),
    .rx_thr   (rx_thr_q),
    .eng_busy (eng_busy),
    .ovr_evt  (ovr_evt),
    .clr      (clr_w),
    .ien      (ien_q),
    .pend     (pend_w),
    .rx_lvl   (rx_lvl),
    .irq      (irq),
    .tx_dma   (tx_dma_req),
    .rx_dma   (rx_dma_req)
  );

  assign tx_avail = !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_thr_q <= reg_wdata[B_TXTHR +: TH_W];
        rx_thr_q <= reg_wdata[B_RXTHR +: TH_W];
      end
      if (reg_wr && (reg_addr == A_IEN)) ien_q <= reg_wdata[IRQ_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[B_TXTHR +: TH_W] = tx_thr_q;
        rd_mux[B_RXTHR +: TH_W] = rx_thr_q;
      end
      A_STAT: begin
        rd_mux[B_RXNE] = !rx_empty;
        rd_mux[B_BUSY] = eng_busy || !tx_empty;
      end
      A_IEN:   rd_mux[IRQ_W-1:0] = ien_q;
      A_ISTAT: begin
        rd_mux[IRQ_W-1:0] = pend_w;
        rd_mux[B_RXLVL]   = rx_lvl;
      end
      A_DATA:  rd_mux = rx_empty ? '0 : rx_head;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/txrxq_checker.sv
module txrxq_checker
  import txrxq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             tx_pop,
  input logic             tx_avail,
  input logic             rx_push,
  input logic             irq,
  input logic             tx_dma_req,
  input logic             rx_dma_req,
  input logic [IRQ_W-1:0] ien_q,
  input logic [IRQ_W-1:0] pend_w,
  input logic [CW-1:0]    tx_cnt,
  input logic [CW-1:0]    rx_cnt
);

  a_r4_tx_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[B_TXFLUSH]) |=> !tx_avail);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ((pend_w & ien_q & PEND_MASK) == '0) |=> !irq);

  a_r10_txdma_gated: assert property (@(posedge clk) disable iff (rst)
    !ien_q[B_TXDMA] |=> !tx_dma_req);

  a_r10_rxdma_gated: assert property (@(posedge clk) disable iff (rst)
    !ien_q[B_RXDMA] |=> !rx_dma_req);

  a_r6_overrun_flags: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_cnt == CW'(DEPTH)) |=> pend_w[B_OVR]);

  a_r2_tx_level_stable: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !tx_pop) |=> $stable(tx_cnt));

  a_r3_rx_bounded: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));

endmodule

bind txrxq_top txrxq_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .tx_pop     (tx_pop),
  .tx_avail   (tx_avail),
  .rx_push    (rx_push),
  .irq        (irq),
  .tx_dma_req (tx_dma_req),
  .rx_dma_req (rx_dma_req),
  .ien_q      (ien_q),
  .pend_w     (pend_w),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt)
);

// File: tb/test_txrxq_top.sv
module test_txrxq_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  localparam logic [2:0] O_CTRL = 3'd0, O_STAT = 3'd1, O_IEN = 3'd2,
                         O_ISTAT = 3'd3, O_DATA = 3'd4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          tx_pop = 1'b0;
  logic [DW-1:0] tx_word;
  logic          tx_avail;
  logic          rx_push = 1'b0;
  logic [DW-1:0] rx_word = '0;
  logic          eng_busy = 1'b0;
  logic          irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txrxq_top #(.DW(DW), .DEPTH(DEPTH)) i_txrxq_top (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .tx_pop, .tx_word, .tx_avail, .rx_push, .rx_word, .eng_busy,
    .irq, .tx_dma_req, .rx_dma_req
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push_rx(input logic [31:0] d);
    @(negedge clk);
    rx_push = 1'b1; rx_word = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [31:0] d);
    @(negedge clk);
    d = tx_word; tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 tx_avail", 32'(tx_avail), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma", {30'd0, tx_dma_req, rx_dma_req}, 0);
    rd(O_STAT, v);  chk("R1 status", v, 0);
    rd(O_CTRL, v);  chk("R1 control", v, 0);
    rd(O_IEN, v);   chk("R1 enable", v, 0);
  endtask

  task automatic t_tx_path();
    logic [31:0] v;
    int n;
    wr(O_DATA, 32'hA1); wr(O_DATA, 32'hB2); wr(O_DATA, 32'hC3);
    settle();
    chk("R2 avail", 32'(tx_avail), 1);
    pop_tx(v); chk("R2 order0", v, 32'hA1);
    pop_tx(v); chk("R2 order1", v, 32'hB2);
    pop_tx(v); chk("R2 order2", v, 32'hC3);
    chk("R2 drained", 32'(tx_avail), 0);
    for (int i = 0; i < DEPTH + 1; i++) wr(O_DATA, 32'h100 + i);
    n = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      if (tx_avail) begin
        pop_tx(v);
        chk("R2 full order", v, 32'h100 + n);
        n++;
      end
    end
    chk("R2 write past full dropped", n, DEPTH);
  endtask

  task automatic t_rx_path();
    logic [31:0] v;
    rd(O_STAT, v); chk("R5 rx empty", v, 0);
    push_rx(32'h11); push_rx(32'h22); push_rx(32'h33);
    rd(O_STAT, v); chk("R5 rx not empty", v, 32'h1);
    rd(O_DATA, v); chk("R3 R11 rx0", v, 32'h11);
    rd(O_DATA, v); chk("R3 R11 rx1", v, 32'h22);
    rd(O_DATA, v); chk("R3 R11 rx2", v, 32'h33);
    rd(O_DATA, v); chk("R3 empty read", v, 0);
    rd(O_STAT, v); chk("R5 rx empty again", v, 0);
    eng_busy = 1'b1;
    rd(O_STAT, v); chk("R5 busy", v, 32'h80);
    eng_busy = 1'b0;
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(O_CTRL, 32'h503);
    rd(O_CTRL, v); chk("R4 thresholds", v, 32'h503);
    push_rx(32'h5); push_rx(32'h6);
    wr(O_CTRL, 32'h513);
    rd(O_STAT, v); chk("R4 rx flush", v, 0);
    rd(O_CTRL, v); chk("R4 flush bits read 0", v, 32'h503);
    wr(O_DATA, 32'h7); wr(O_DATA, 32'h8);
    wr(O_CTRL, 32'h1503);
    settle();
    chk("R4 tx flush", 32'(tx_avail), 0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    wr(O_CTRL, 32'h10);
    wr(O_ISTAT, 32'h19);
    rd(O_ISTAT, v); chk("R6 no overrun", v & 1, 0);
    for (int i = 0; i < DEPTH + 1; i++) push_rx(32'h200 + i);
    settle();
    rd(O_ISTAT, v); chk("R6 overrun set", v & 1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(O_DATA, v); chk("R6 kept words", v, 32'h200 + i);
    end
    rd(O_DATA, v); chk("R6 ninth dropped", v, 0);
    wr(O_ISTAT, 32'h1);
    rd(O_ISTAT, v); chk("R8 overrun cleared", v & 1, 0);
  endtask

  task automatic t_rx_done();
    logic [31:0] v;
    wr(O_CTRL, 32'h13);
    wr(O_ISTAT, 32'h19);
    wr(O_IEN, 32'h08);
    push_rx(32'h1); push_rx(32'h2);
    settle();
    rd(O_ISTAT, v); chk("R7 below threshold", v & 32'h208, 0);
    chk("R9 irq low", 32'(irq), 0);
    push_rx(32'h3);
    settle();
    rd(O_ISTAT, v); chk("R7 threshold reached", v & 32'h208, 32'h208);
    settle();
    chk("R9 irq high", 32'(irq), 1);
    wr(O_ISTAT, 32'h0);
    rd(O_ISTAT, v); chk("R8 write 0 keeps", v & 32'h8, 32'h8);
    for (int i = 0; i < 3; i++) rd(O_DATA, v);
    wr(O_ISTAT, 32'h8);
    rd(O_ISTAT, v); chk("R8 rx done cleared", v & 32'h208, 0);
    settle();
    chk("R9 irq after clear", 32'(irq), 0);
    push_rx(32'h4); push_rx(32'h5); push_rx(32'h6);
    settle();
    chk("R9 irq again", 32'(irq), 1);
    wr(O_IEN, 32'h0);
    settle();
    chk("R9 irq disabled", 32'(irq), 0);
    wr(O_CTRL, 32'h13);
    wr(O_ISTAT, 32'h19);
  endtask

  task automatic t_tx_done();
    logic [31:0] v;
    settle();
    rd(O_ISTAT, v); chk("R7 tx done idle", v & 32'h10, 32'h10);
    wr(O_DATA, 32'h9);
    wr(O_ISTAT, 32'h10);
    rd(O_ISTAT, v); chk("R8 tx done cleared", v & 32'h10, 0);
    pop_tx(v);
    settle();
    rd(O_ISTAT, v); chk("R7 tx done after drain", v & 32'h10, 32'h10);
    eng_busy = 1'b1;
    wr(O_ISTAT, 32'h10);
    rd(O_ISTAT, v); chk("R7 busy holds off", v & 32'h10, 0);
    eng_busy = 1'b0;
    settle();
    rd(O_ISTAT, v); chk("R7 idle sets", v & 32'h10, 32'h10);
  endtask

  task automatic t_dma();
    wr(O_CTRL, 32'h402);
    wr(O_IEN, 32'h06);
    settle();
    chk("R10 tx req free 8", 32'(tx_dma_req), 1);
    chk("R10 rx req empty", 32'(rx_dma_req), 0);
    for (int i = 0; i < 5; i++) wr(O_DATA, 32'h300 + i);
    settle();
    chk("R10 tx req free 3", 32'(tx_dma_req), 0);
    push_rx(32'h1);
    settle();
    chk("R10 rx req one word", 32'(rx_dma_req), 0);
    push_rx(32'h2);
    settle();
    chk("R10 rx req two words", 32'(rx_dma_req), 1);
    wr(O_IEN, 32'h0);
    settle();
    chk("R10 disabled", {30'd0, tx_dma_req, rx_dma_req}, 0);
    wr(O_CTRL, 32'h1410);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_path();
    t_rx_path();
    t_ctrl();
    t_overrun();
    t_rx_done();
    t_tx_done();
    t_dma();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule